// File: doc/BRIEF.md
# AXI4 Write Path Width Converter, 64-bit to 32-bit

This block joins a 64-bit AXI4 write master to a 32-bit AXI4 slave. It converts the write-address and write-data channels and passes the write-response channel through unchanged. Only one burst is in flight at a time. The block accepts an address, forwards a rewritten address to the slave and streams the data beats through a one-beat holding register. It returns the slave's response and only then accepts the next address.

For a narrow beat (size 0, 1 or 2), the block keeps a running byte address. Bit 2 of that address picks the 32-bit half of the 64-bit word that carries the valid lanes, and that half becomes one output beat. A full-width beat (size 3) becomes two output beats. The burst's start-address bit 2 decides which half goes first. Because of this, the output burst length and the last-beat marker are recomputed. A full-width burst that needs more than 256 output beats is flagged as unsupported. A master last marker that disagrees with the beat count is also flagged.

Top module: `axi_wr_downsizer`

## Requirements
- R1: After reset the block offers address ready and withholds data ready, both output valids are low and both error flags are low.
- R2: A narrow burst (size 0, 1 or 2) is forwarded with its size, length, address, id and burst type unchanged. A full-width burst (size 3) is forwarded with size 2 and length 2*len+1, keeping only the low 8 bits.
- R3: The unsupported-length flag rises after a full-width burst with len of 128 or more is accepted. It stays low for every other burst and is cleared when the next address is accepted.
- R4: A narrow beat whose byte address has bit 2 clear forwards data[31:0] and strobe[3:0] unchanged. With bit 2 set, it forwards data[63:32] and strobe[7:4] on the low lanes, so strobe 0x30 becomes 0x3. Beat addresses of an incrementing burst (type 1) step by the transfer size from the size-aligned start.
- R5: A full-width beat becomes two output beats. The first is the low half when start-address bit 2 is 0 and the high half when it is 1. The second is the other half.
- R6: No new master data beat is accepted while the held beat still has an output part that the slave is not taking in the same cycle.
- R7: Output last is high only on the final output beat of the converted burst. After it is accepted, no further output data beat appears for that burst.
- R8: The last-mismatch flag rises when a master beat's last marker differs from "this is beat len". Data still flows by count, and the flag is cleared on the next address.
- R9: The slave's response valid, id and code reach the master unchanged, and the master's response ready reaches the slave.
- R10: A stalled output address or data beat keeps its valid high and its contents stable until it is accepted.
- R11: In a fixed burst (type 0) the beat address does not advance, so every narrow beat uses the same half.
- R12: A new address is not accepted until the response of the current burst has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awid | input | ID_W | Master write id |
| s_awaddr | input | ADDR_W | Master burst start address |
| s_awlen | input | 8 | Master beats minus one |
| s_awsize | input | 3 | Master transfer size (log2 bytes) |
| s_awburst | input | 2 | Master burst type (0 fixed, 1 incrementing) |
| s_awvalid | input | 1 | Master address valid |
| s_awready | output | 1 | Address accepted |
| s_wdata | input | 64 | Master write data |
| s_wstrb | input | 8 | Master byte strobes |
| s_wlast | input | 1 | Master last beat marker |
| s_wvalid | input | 1 | Master data valid |
| s_wready | output | 1 | Data accepted |
| s_bid | output | ID_W | Response id to master |
| s_bresp | output | 2 | Response code to master |
| s_bvalid | output | 1 | Response valid to master |
| s_bready | input | 1 | Master response ready |
| m_awid | output | ID_W | Slave write id |
| m_awaddr | output | ADDR_W | Slave start address |
| m_awlen | output | 8 | Slave beats minus one |
| m_awsize | output | 3 | Slave transfer size |
| m_awburst | output | 2 | Slave burst type |
| m_awvalid | output | 1 | Slave address valid |
| m_awready | input | 1 | Slave address ready |
| m_wdata | output | 32 | Slave write data |
| m_wstrb | output | 4 | Slave byte strobes |
| m_wlast | output | 1 | Slave last beat marker |
| m_wvalid | output | 1 | Slave data valid |
| m_wready | input | 1 | Slave data ready |
| m_bid | input | ID_W | Slave response id |
| m_bresp | input | 2 | Slave response code |
| m_bvalid | input | 1 | Slave response valid |
| m_bready | output | 1 | Response ready to slave |
| err_len | output | 1 | Unsupported converted length |
| err_last | output | 1 | Master last marker mismatch |

## Verification
The bench goes after half selection at start addresses with bit 2 set. It uses both directed strobe patterns, 0x03/0x0C/0x30/0xC0 and 0xF0 then 0x0F. A converter that ignored the address would put zero strobes on the slave, and one that split full beats in a fixed order would swap the halves. Fixed bursts check that the half does not drift as it would if the address stepped. A 201-beat full-width burst checks the length flag and the truncated length while the last marker still lands on output beat 402. A premature master last checks that the burst is neither cut short nor extended. Random slave stalls expose a converter that takes a new beat before the second half has gone out, or that drops a half.

// File: rtl/axi_wr_downsizer.sv
module axi_wr_downsizer #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   s_awid,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [7:0]        s_awlen,
  input  logic [2:0]        s_awsize,
  input  logic [1:0]        s_awburst,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [63:0]       s_wdata,
  input  logic [7:0]        s_wstrb,
  input  logic              s_wlast,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ID_W-1:0]   m_awid,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [31:0]       m_wdata,
  output logic [3:0]        m_wstrb,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [ID_W-1:0]   m_bid,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic              err_len,
  output logic              err_last
);

  logic        busy, w_en, in_done, full_q, fix_q, b2_start, phase;
  logic [2:0]  size_q, a_lo, a_nxt;
  logic [3:0]  step;
  logic [7:0]  in_left;
  logic [8:0]  out_left;
  logic        hv;
  logic [63:0] hd;
  logic [7:0]  hs;
  logic        aw_hs, wi_hs, wo_hs, lastpart, drain, half;

  assign aw_hs     = s_awvalid && !busy;
  assign s_awready = !busy;

  assign wo_hs    = hv && m_wready;
  assign lastpart = !full_q || phase;
  assign drain    = wo_hs && lastpart;
  assign s_wready = w_en && !in_done && (!hv || drain);
  assign wi_hs    = s_wvalid && s_wready;

  assign half     = full_q ? (b2_start ^ phase) : a_lo[2];
  assign m_wvalid = hv;
  assign m_wdata  = half ? hd[63:32] : hd[31:0];
  assign m_wstrb  = half ? hs[7:4]   : hs[3:0];
  assign m_wlast  = hv && (out_left == 9'd0);

  assign step  = 4'd1 << size_q;
  assign a_nxt = 3'(({1'b0, a_lo} & ~(step - 4'd1)) + step);

  assign s_bid    = m_bid;
  assign s_bresp  = m_bresp;
  assign s_bvalid = m_bvalid;
  assign m_bready = s_bready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; w_en <= 1'b0; in_done <= 1'b0; full_q <= 1'b0;
      fix_q <= 1'b0; b2_start <= 1'b0; phase <= 1'b0; size_q <= '0;
      a_lo <= '0; in_left <= '0; out_left <= '0; hv <= 1'b0;
      hd <= '0; hs <= '0; err_len <= 1'b0; err_last <= 1'b0;
      m_awid <= '0; m_awaddr <= '0; m_awlen <= '0; m_awsize <= '0;
      m_awburst <= '0; m_awvalid <= 1'b0;
    end else begin
      if (aw_hs) begin
        busy     <= 1'b1;
        w_en     <= 1'b1;
        in_done  <= 1'b0;
        full_q   <= (s_awsize == 3'd3);
        fix_q    <= (s_awburst == 2'd0);
        b2_start <= s_awaddr[2];
        size_q   <= s_awsize;
        a_lo     <= s_awaddr[2:0];
        in_left  <= s_awlen;
        out_left <= (s_awsize == 3'd3) ? {s_awlen, 1'b1} : {1'b0, s_awlen};
        err_len  <= (s_awsize == 3'd3) && s_awlen[7];
        err_last <= 1'b0;
        m_awid    <= s_awid;
        m_awaddr  <= s_awaddr;
        m_awlen   <= (s_awsize == 3'd3) ? {s_awlen[6:0], 1'b1} : s_awlen;
        m_awsize  <= (s_awsize == 3'd3) ? 3'd2 : s_awsize;
        m_awburst <= s_awburst;
        m_awvalid <= 1'b1;
      end else if (m_awvalid && m_awready) begin
        m_awvalid <= 1'b0;
      end

      if (wo_hs) begin
        if (out_left != 9'd0) out_left <= out_left - 9'd1;
        else                  w_en <= 1'b0;
        phase <= full_q && !phase;
        if (!full_q && !fix_q) a_lo <= a_nxt;
      end

      if (wi_hs) begin
        hd <= s_wdata;
        hs <= s_wstrb;
        hv <= 1'b1;
        if (in_left != 8'd0) in_left <= in_left - 8'd1;
        in_done <= (in_left == 8'd0);
        if (s_wlast != (in_left == 8'd0)) err_last <= 1'b1;
      end else if (drain) begin
        hv <= 1'b0;
      end

      if (m_bvalid && s_bready) busy <= 1'b0;
    end
  end

endmodule

module axi_wr_downsizer_chk #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              s_wvalid,
  input logic              s_wready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic [7:0]        m_awlen,
  input logic [2:0]        m_awsize,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [31:0]       m_wdata,
  input logic [3:0]        m_wstrb,
  input logic              m_wlast,
  input logic              m_wvalid,
  input logic              m_wready
);

  a_r10_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wstrb) && $stable(m_wlast));

  a_r10_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen) && $stable(m_awsize));

  a_r2_out_size: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> m_awsize <= 3'd2);

  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    s_wvalid && s_wready |-> !m_wvalid || m_wready);

  a_r12_single_burst: assert property (@(posedge clk) disable iff (!rst_n)
    s_awvalid && s_awready |=> !s_awready);

  a_r7_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && m_wready && m_wlast |=> !m_wvalid);

endmodule

bind axi_wr_downsizer axi_wr_downsizer_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/axi_wr_downsizer_bench.sv
module axi_wr_downsizer_bench;
  localparam int ID_W = 4;
  localparam int ADDR_W = 32;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [ID_W-1:0] s_awid = '0, s_bid, m_awid, m_bid = '0;
  logic [ADDR_W-1:0] s_awaddr = '0, m_awaddr;
  logic [7:0] s_awlen = '0, m_awlen, s_wstrb = '0;
  logic [2:0] s_awsize = '0, m_awsize;
  logic [1:0] s_awburst = '0, m_awburst, s_bresp, m_bresp = '0;
  logic s_awvalid = 0, s_awready, s_wlast = 0, s_wvalid = 0, s_wready;
  logic s_bvalid, s_bready = 0, m_awvalid, m_awready = 0;
  logic [63:0] s_wdata = '0;
  logic [31:0] m_wdata;
  logic [3:0] m_wstrb;
  logic m_wlast, m_wvalid, m_wready = 0, m_bvalid = 0, m_bready, err_len, err_last;

  axi_wr_downsizer #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_axi_wr_downsizer (.*);

  int checks = 0, fails = 0;
  logic [63:0] in_d [0:255];
  logic [7:0]  in_s [0:255];
  logic [31:0] ex_d [0:511];
  logic [3:0]  ex_s [0:511];
  int nexp;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit beat_b2(input logic [31:0] a, input int sz, input int bt, input int i);
    logic [31:0] x;
    if (bt == 0 || i == 0) return a[2];
    x = ((a >> sz) << sz) + 32'(i * (1 << sz));
    return x[2];
  endfunction

  function automatic logic [7:0] lane_mask(input logic [31:0] a, input int sz, input int bt, input int i);
    logic [31:0] x;
    if (sz == 3) return 8'hFF;
    x = (bt == 0 || i == 0) ? a : ((a >> sz) << sz) + 32'(i * (1 << sz));
    x = (x >> sz) << sz;
    return 8'(((1 << (1 << sz)) - 1) << x[2:0]);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      m_awready = ($urandom % 4) != 0;
      m_wready  = ($urandom % 3) != 0;
      s_bready  = ($urandom % 2) != 0;
    end
  end

  task automatic run_burst(input logic [31:0] addr, input int len, input int sz, input int bt,
                           input bit preset, input bit bad_last);
    logic [ID_W-1:0] id;
    logic [1:0] resp;
    bit awseen, hs, r6_bad;
    int k;
    id = ID_W'($urandom);
    resp = 2'($urandom);
    for (int i = 0; i <= len; i++) if (!preset) begin
      in_d[i] = {$urandom, $urandom};
      in_s[i] = 8'($urandom) & lane_mask(addr, sz, bt, i);
    end
    nexp = 0;
    for (int i = 0; i <= len; i++) begin
      if (sz == 3) begin
        for (int p = 0; p < 2; p++) begin
          bit h = addr[2] ^ p[0];
          ex_d[nexp] = h ? in_d[i][63:32] : in_d[i][31:0];
          ex_s[nexp] = h ? in_s[i][7:4] : in_s[i][3:0];
          nexp++;
        end
      end else begin
        bit h = beat_b2(addr, sz, bt, i);
        ex_d[nexp] = h ? in_d[i][63:32] : in_d[i][31:0];
        ex_s[nexp] = h ? in_s[i][7:4] : in_s[i][3:0];
        nexp++;
      end
    end
    fork
      begin
        @(negedge clk);
        s_awid = id; s_awaddr = addr; s_awlen = 8'(len); s_awsize = 3'(sz);
        s_awburst = 2'(bt); s_awvalid = 1;
        do begin #2; hs = s_awready; @(negedge clk); end while (!hs);
        s_awvalid = 0;
        for (int i = 0; i <= len; i++) begin
          s_wdata = in_d[i]; s_wstrb = in_s[i];
          s_wlast = bad_last ? (i == 0) : (i == len);
          s_wvalid = 1;
          do begin #2; hs = s_wready; @(negedge clk); end while (!hs);
        end
        s_wvalid = 0; s_wlast = 0;
      end
      begin
        k = 0; awseen = 0; r6_bad = 0;
        while (k < nexp || !awseen) begin
          @(negedge clk); #2;
          if (s_wvalid && s_wready && m_wvalid && !m_wready) r6_bad = 1;
          if (m_awvalid && m_awready && !awseen) begin
            awseen = 1;
            chk(m_awsize == ((sz == 3) ? 3'd2 : 3'(sz)), "R2", "out size", m_awsize, sz);
            chk(m_awlen == ((sz == 3) ? 8'(2 * len + 1) : 8'(len)), "R2", "out len", m_awlen, len);
            chk(m_awaddr == addr && m_awid == id && m_awburst == 2'(bt), "R2", "out addr", m_awaddr, addr);
          end
          if (m_wvalid && m_wready) begin
            if (k < nexp) begin
              chk(m_wdata == ex_d[k], (sz == 3) ? "R5" : "R4", "data", m_wdata, ex_d[k]);
              chk(m_wstrb == ex_s[k], (sz == 3) ? "R5" : ((bt == 0) ? "R11" : "R4"), "strobe", m_wstrb, ex_s[k]);
              chk(m_wlast == (k == nexp - 1), "R7", "last", m_wlast, k == nexp - 1);
            end else chk(0, "R7", "extra beat", k, nexp);
            k++;
          end
        end
        chk(!r6_bad, "R6", "beat taken over stalled half", r6_bad, 0);
        @(negedge clk); #2;
        chk(!m_wvalid, "R7", "valid after last", m_wvalid, 0);
        chk(err_len == (sz == 3 && len >= 128), "R3", "len flag", err_len, sz == 3 && len >= 128);
        chk(err_last == bad_last, "R8", "last flag", err_last, bad_last);
        @(negedge clk);
        m_bvalid = 1; m_bid = id; m_bresp = resp;
        do begin
          #2;
          hs = s_bready;
          if (hs) begin
            chk(s_bvalid && s_bid == id && s_bresp == resp && m_bready, "R9", "response", s_bresp, resp);
            chk(!s_awready, "R12", "address ready before response", s_awready, 0);
          end
          @(negedge clk);
        end while (!hs);
        m_bvalid = 0;
      end
    join
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk(s_awready && !s_wready && !m_awvalid && !m_wvalid && !err_len && !err_last,
        "R1", "reset state", {s_awready, s_wready, m_awvalid, m_wvalid}, 4'b1000);
    void'($urandom(32'd1234));

    in_s[0] = 8'h03; in_s[1] = 8'h0C; in_s[2] = 8'h30; in_s[3] = 8'hC0;
    for (int i = 0; i < 4; i++) in_d[i] = {$urandom, $urandom};
    run_burst(32'h100, 3, 1, 1, 1, 0);

    in_s[0] = 8'hF0; in_s[1] = 8'h0F;
    for (int i = 0; i < 2; i++) in_d[i] = {$urandom, $urandom};
    run_burst(32'h204, 1, 3, 1, 1, 0);

    run_burst(32'h308, 2, 3, 1, 0, 0);
    run_burst(32'h40C, 3, 2, 0, 0, 0);
    run_burst(32'h506, 5, 1, 0, 0, 0);
    run_burst(32'h600, 2, 0, 1, 0, 1);
    run_burst(32'h1000, 200, 3, 1, 0, 0);
    run_burst(32'h2004, 127, 3, 1, 0, 0);

    for (int n = 0; n < 40; n++) begin
      int sz = $urandom % 4;
      int bt = $urandom % 2;
      logic [31:0] a = ($urandom % 32'h10000) & ~32'((1 << sz) - 1);
      run_burst(a, $urandom % 16, sz, bt, 0, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule